// File: doc/BRIEF.md
# UART Prioritized Interrupt Controller

This block sits in one channel of a serial port and turns a set of raw event conditions into one interrupt line and one encoded status word. Four event classes compete: a line error, received data (trigger reached or character timeout), an empty transmit holding register, and a change on one of the modem handshake inputs. An enable mask gates each class on its own. Of the enabled events that are pending, only the most urgent one appears in the status word, so software services events one at a time.

The block also watches the modem handshake inputs. It passes them through a two-flop synchronizer and latches a sticky change flag for each line. The modem status word has the synchronized line levels in its upper half and the change flags in its lower half. Reading the modem status word clears the change flags. Reading the interrupt status word while it shows the transmit-empty code clears that request. When the whole enable mask is zero the block never raises its interrupt, and software polls instead.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, `isr_o` is 4'b0001 (nothing pending) and all bits of `msr_o` are 0.
- R2: Priority from highest to lowest: line error (`isr_o` = 4'b0110), receive data (4'b0100 or 4'b1100), transmit empty (4'b0010), modem change (4'b0000). Bit 0 of `isr_o` is 1 only when nothing enabled is pending.
- R3: Data-available and character-timeout share the receive level. Data-available shows as 4'b0100, a timeout alone shows as 4'b1100, and when both are present the data-available code wins.
- R4: Enable bits gate each class on its own: `en_i[0]` receive, `en_i[1]` transmit empty, `en_i[2]` line error, `en_i[3]` modem change. A masked source neither raises `irq_o` nor shows in `isr_o`.
- R5: With `en_i` all zero, `irq_o` stays 0 and `isr_o` stays 4'b0001 whatever the sources do. The modem change flags still latch.
- R6: `msr_o[7:4]` carries the modem lines two clock edges after they change. On the third edge, the change flag in `msr_o[3:0]` for each line that toggled is set, and it stays set.
- R7: A cycle with `msr_rd_i` high clears the change flags at the next edge. A line change that is detected at that same edge sets its flag anyway.
- R8: Any nonzero change flag with `en_i[3]` set requests the modem-change level.
- R9: The transmit-empty request sets when `tx_empty_i` rises, or when `en_i[1]` rises while `tx_empty_i` is high. It clears when `tx_empty_i` falls, or on an `isr_rd_i` cycle while `isr_o` shows 4'b0010. An `isr_rd_i` while another code is shown leaves the request in place.
- R10: `irq_o` and `isr_o` are registered. They reflect the sources exactly one clock edge after the sources change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 4 | Interrupt enable mask |
| line_err_i | input | 1 | Line error condition present |
| rx_avail_i | input | 1 | Receive data available / trigger reached |
| rx_timeout_i | input | 1 | Receive character timeout |
| tx_empty_i | input | 1 | Transmit holding register empty |
| modem_i | input | MDM_W | Modem handshake input lines |
| isr_rd_i | input | 1 | Interrupt status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| irq_o | output | 1 | Interrupt request, active high |
| isr_o | output | 4 | Encoded top-priority source |
| msr_o | output | 2*MDM_W | Modem lines (upper) and change flags (lower) |

## Verification
The bench stacks sources so that each one is shown or hidden by a higher one. A wrong priority order or a wrong receive sub-code would then show the wrong status word. It reads the interrupt status both while the transmit code is shown and while a line error covers it. A design that clears the transmit request on any read would lose the transmit code after the line error goes away. It pulses the modem-status read on the exact edge where a new change is detected. A design that gives the clear priority would drop that new flag and the interrupt. It also raises the transmit enable while the register is already empty, and a design that sets the request only on the edge of the empty condition would never request.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int MDM_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         en_i,
  input  logic               line_err_i,
  input  logic               rx_avail_i,
  input  logic               rx_timeout_i,
  input  logic               tx_empty_i,
  input  logic [MDM_W-1:0]   modem_i,
  input  logic               isr_rd_i,
  input  logic               msr_rd_i,
  output logic               irq_o,
  output logic [3:0]         isr_o,
  output logic [2*MDM_W-1:0] msr_o
);

  localparam logic [3:0] CODE_NONE = 4'b0001;
  localparam logic [3:0] CODE_LINE = 4'b0110;
  localparam logic [3:0] CODE_RXD  = 4'b0100;
  localparam logic [3:0] CODE_RXTO = 4'b1100;
  localparam logic [3:0] CODE_TXE  = 4'b0010;
  localparam logic [3:0] CODE_MDM  = 4'b0000;

  logic [MDM_W-1:0] sync1, sync2, last, delta;
  logic             txe_q, txen_q, tx_req;
  logic             irq_q;
  logic [3:0]       isr_q, code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
      delta <= '0;
    end else begin
      sync1 <= modem_i;
      sync2 <= sync1;
      last  <= sync2;
      delta <= (delta & ~{MDM_W{msr_rd_i}}) | (sync2 ^ last);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q  <= 1'b0;
      txen_q <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      txe_q  <= tx_empty_i;
      txen_q <= en_i[1];
      if (!tx_empty_i)
        tx_req <= 1'b0;
      else if (!txe_q || (en_i[1] && !txen_q))
        tx_req <= 1'b1;
      else if (isr_rd_i && isr_q == CODE_TXE)
        tx_req <= 1'b0;
    end
  end

  always_comb begin
    if (line_err_i && en_i[2])        code = CODE_LINE;
    else if (rx_avail_i && en_i[0])   code = CODE_RXD;
    else if (rx_timeout_i && en_i[0]) code = CODE_RXTO;
    else if (tx_req && en_i[1])       code = CODE_TXE;
    else if ((|delta) && en_i[3])     code = CODE_MDM;
    else                              code = CODE_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      isr_q <= CODE_NONE;
    end else begin
      irq_q <= (code != CODE_NONE);
      isr_q <= code;
    end
  end

  assign irq_o = irq_q;
  assign isr_o = isr_q;
  assign msr_o = {sync2, delta};

endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int MDM_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3:0]         en_i,
  input logic               line_err_i,
  input logic               msr_rd_i,
  input logic               irq_o,
  input logic [3:0]         isr_o,
  input logic [2*MDM_W-1:0] msr_o
);

  assert_polled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == 4'b0000) |=> !irq_o);

  assert_line_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_err_i && en_i[2]) |=> (isr_o == 4'b0110));

  assert_irq_matches_isr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !isr_o[0]);

  assert_msr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd_i && $stable(msr_o[2*MDM_W-1:MDM_W])) |=> (msr_o[MDM_W-1:0] == '0));

  assert_modem_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((msr_o[MDM_W-1:0] != '0) && en_i[3]) |=> irq_o);

  assert_rise_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(en_i) != 4'b0000));

endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.MDM_W(MDM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .line_err_i(line_err_i),
  .msr_rd_i(msr_rd_i), .irq_o(irq_o), .isr_o(isr_o), .msr_o(msr_o)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] en_i = '0;
  logic line_err_i = 0, rx_avail_i = 0, rx_timeout_i = 0, tx_empty_i = 0;
  logic [3:0] modem_i = '0;
  logic isr_rd_i = 0, msr_rd_i = 0;
  logic irq_o;
  logic [3:0] isr_o;
  logic [7:0] msr_o;

  uart_irq_ctrl #(.MDM_W(4)) u0 (.*);

  always #4 clk = ~clk;

  typedef struct {
    int         cyc;
    logic       irq;
    logic [3:0] isr;
    logic [7:0] msr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int d, input logic irq, input logic [3:0] isr,
                           input logic [7:0] msr, input string tag);
    exp_t e;
    e.cyc = cyc + d; e.irq = irq; e.isr = isr; e.msr = msr; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irq_o !== e.irq || isr_o !== e.isr || msr_o !== e.msr) begin
        fails++;
        $display("FAIL %s: irq=%b isr=%b msr=%h expected irq=%b isr=%b msr=%h",
                 e.tag, irq_o, isr_o, msr_o, e.irq, e.isr, e.msr);
      end
    end
  end

  initial begin
    edges(3);
    rst_n = 1'b1;
    expect_at(1, 0, 4'b0001, 8'h00, "R1 reset state");
    edges(2);

    // polled mode: all sources active, nothing enabled
    line_err_i = 1; rx_avail_i = 1; tx_empty_i = 1;
    expect_at(2, 0, 4'b0001, 8'h00, "R5 polled no irq");
    edges(3);
    modem_i = 4'b0001;
    expect_at(2, 0, 4'b0001, 8'h10, "R6 lines after two edges");
    expect_at(4, 0, 4'b0001, 8'h11, "R5 R6 delta latches while polled");
    edges(5);

    en_i = 4'hF;
    expect_at(1, 1, 4'b0110, 8'h11, "R2 R10 line error first");
    edges(2);
    line_err_i = 0;
    expect_at(1, 1, 4'b0100, 8'h11, "R2 receive data next");
    edges(2);
    rx_avail_i = 0; rx_timeout_i = 1;
    expect_at(1, 1, 4'b1100, 8'h11, "R3 timeout code");
    edges(2);
    rx_avail_i = 1;
    expect_at(1, 1, 4'b0100, 8'h11, "R3 data wins over timeout");
    edges(2);
    rx_avail_i = 0; rx_timeout_i = 0;
    expect_at(1, 1, 4'b0010, 8'h11, "R2 transmit empty next");
    edges(2);

    isr_rd_i = 1;
    expect_at(1, 1, 4'b0010, 8'h11, "R10 isr one edge late");
    expect_at(2, 1, 4'b0000, 8'h11, "R9 isr read clears tx, modem shown");
    edges(1);
    isr_rd_i = 0;
    edges(2);

    msr_rd_i = 1;
    expect_at(1, 1, 4'b0000, 8'h10, "R7 msr read clears flags");
    expect_at(2, 0, 4'b0001, 8'h10, "R8 modem request gone");
    edges(1);
    msr_rd_i = 0;
    edges(2);

    en_i = 4'b0111;
    modem_i = 4'b0000;
    expect_at(3, 0, 4'b0001, 8'h01, "R6 falling edge flagged");
    expect_at(4, 0, 4'b0001, 8'h01, "R4 modem masked");
    edges(5);
    en_i = 4'hF;
    expect_at(1, 1, 4'b0000, 8'h01, "R8 modem level requested");
    edges(2);

    modem_i = 4'b0010;
    expect_at(2, 1, 4'b0000, 8'h21, "R6 line visible");
    expect_at(3, 1, 4'b0000, 8'h22, "R7 new change wins over clear");
    expect_at(4, 1, 4'b0000, 8'h22, "R8 still requested");
    edges(2);
    msr_rd_i = 1;
    edges(1);
    msr_rd_i = 0;
    edges(2);
    msr_rd_i = 1;
    expect_at(1, 1, 4'b0000, 8'h20, "R7 flags cleared");
    expect_at(2, 0, 4'b0001, 8'h20, "R7 irq drops");
    edges(1);
    msr_rd_i = 0;
    edges(2);

    en_i = 4'b1101;
    edges(2);
    en_i = 4'hF;
    expect_at(1, 0, 4'b0001, 8'h20, "R9 enable rise not yet shown");
    expect_at(2, 1, 4'b0010, 8'h20, "R9 enable rise while empty");
    edges(3);
    tx_empty_i = 0;
    expect_at(2, 0, 4'b0001, 8'h20, "R9 empty falls clears");
    edges(3);
    tx_empty_i = 1;
    expect_at(2, 1, 4'b0010, 8'h20, "R9 empty rise sets");
    edges(3);

    line_err_i = 1;
    expect_at(1, 1, 4'b0110, 8'h20, "R2 line error hides tx");
    edges(1);
    isr_rd_i = 1; line_err_i = 0;
    expect_at(1, 1, 4'b0010, 8'h20, "R9 read of other code keeps tx");
    edges(1);
    isr_rd_i = 0;
    expect_at(2, 1, 4'b0010, 8'h20, "R9 tx still pending");
    edges(4);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule